// File: doc/BRIEF.md
# I2C Serial EEPROM Target Front End

This block is the bus side of a small byte-wide serial memory that answers on an I2C bus as a target. A fast system clock oversamples the serial clock and data lines, finds Start and Stop conditions, and shifts bytes in and out. The first byte after a Start is a select byte. It names the device type, picks the chip by its enable pins and, for larger arrays, carries the top bits of the memory address in place of those pins. Write commands then carry a byte address and data. Read commands stream bytes out from an internal address counter.

Data bytes go into a byte-wide array held inside the block. The array is written so that an FPGA block RAM can be inferred, and it starts erased at FFh. A Stop that directly follows an acknowledged data byte sends a one-cycle commit pulse to a separate page commit block. That block answers with a busy level. While busy is high, no select byte is acknowledged, so a host can poll for the end of the write cycle. A write-protect input keeps data bytes out of the array and withholds their acknowledge. The data line is open drain: the block only ever pulls it low.

Top module: `i2c_ee_target`

## Requirements
- R1: A falling data edge while the clock is high (Start) aborts any transfer in progress and restarts select-byte reception. A rising data edge while the clock is high (Stop) returns the block to standby with the data line released.
- R2: A select byte is received MSB first and acknowledged only if its bits 7..4 are 1010 and the enable bits that are compared equal the enable pins. On a mismatch the block pulls nothing and ignores the bus until the next Start.
- R3: With the default 512-byte array, select bit 1 is address bit A8 and is not compared. Bits 3 and 2 are compared with pins 2 and 1. Writing with A8 = 1 and A8 = 0 reaches two different locations.
- R4: In write mode the select byte, the address byte and every data byte (write protect low) are acknowledged by holding SDA low for the 9th clock. Each data byte is stored at the current address. The data line is pulled low only after a falling clock edge has been seen.
- R5: During a multi-byte write only the lowest log2(PAGE_BYTES) address bits (4 by default) advance, so bytes past the end of a 16-byte page wrap to its start.
- R6: With write protect high, the select and address bytes are still acknowledged, data bytes are not, and the array keeps its contents.
- R7: The commit output pulses for one cycle on a Stop that comes directly after an acknowledged data byte. It stays low for a Stop after only an address byte and after write-protected data.
- R8: While the busy input is high, no select byte is acknowledged.
- R9: A random read loads the address with a write command, then issues a repeated Start and a select byte with read/write = 1. The block then returns the byte at that address, MSB first.
- R10: A select byte with read/write = 1 alone reads from the internal counter, with the counter's high bits taken from the select byte. The counter advances after every byte read and wraps from the last address to 0.
- R11: After a read byte, a high data line in the 9th clock (no acknowledge) ends the read: the block releases the line and waits for a Start.
- R12: After reset the data line is released, commit is low, and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_low_o | output | 1 | When high, the block pulls the data line low |
| ce_i | input | 3 | Chip-enable pins; bits masked by high address bits are unused |
| wp_i | input | 1 | Write protect; high blocks data writes |
| busy_i | input | 1 | High while the external commit block runs a write cycle |
| commit_o | output | 1 | One-cycle pulse requesting a write cycle |

## Verification
The assertions assume a well-formed bus. The data line changes only while the clock is low, except for Start and Stop. Write protect changes only between transactions. Busy rises only after a commit pulse and never while a select byte is being acknowledged. The bench master drives every bit with a fixed quarter-period spacing that is many system clocks wide. It changes the data line only in the low phase of the clock. It holds write protect steady for a whole command and raises busy only from its own model of the commit block, after each commit pulse.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_VAL}};
      prev  <= IDLE_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ee_ram.sv
module ee_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = {WIDTH{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
  import ee_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 512,
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  input  logic [2:0] ce_i,
  input  logic       wp_i,
  input  logic       busy_i,
  output logic       commit_o
);
  localparam int unsigned AW = $clog2(MEM_BYTES);
  localparam int unsigned HB = (AW > 8) ? AW - 8 : 0;
  localparam int unsigned PW = $clog2(PAGE_BYTES);
  localparam logic [2:0]  CE_MASK   = 3'(3'b111 << HB);
  localparam logic [AW-1:0] PG_MASK = AW'((1 << PW) - 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  ee_line_sync #(.STAGES(2), .IDLE_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  ee_line_sync #(.STAGES(2), .IDLE_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  logic start_evt, stop_evt;
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;

  ee_state_e     st;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [7:0]    out_sh;
  logic [AW-1:0] addr;
  logic          rw;
  logic          pending;
  logic          more;
  logic          ram_we;
  logic [AW-1:0] wa;
  logic [7:0]    wd;
  logic [7:0]    rd_q;

  ee_ram #(.DEPTH(MEM_BYTES), .WIDTH(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wa), .wdata(wd),
    .raddr(addr), .rdata(rd_q)
  );

  logic [7:0]    addr_lo8;
  logic [2:0]    addr_hi3;
  logic          sel_hit;
  logic          rx_state;
  logic [AW-1:0] page_next;

  assign addr_lo8  = 8'(addr);
  assign addr_hi3  = 3'(addr >> 8);
  assign sel_hit   = (shreg[7:4] == DEV_TYPE) &&
                     (((shreg[3:1] ^ ce_i) & CE_MASK) == 3'b000) && !busy_i;
  assign rx_state  = (st == ST_SEL) || (st == ST_ADDR) || (st == ST_WDATA);
  assign page_next = (addr & ~PG_MASK) | ((addr + 1'b1) & PG_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      out_sh    <= '0;
      addr      <= '0;
      rw        <= 1'b0;
      pending   <= 1'b0;
      more      <= 1'b0;
      ram_we    <= 1'b0;
      wa        <= '0;
      wd        <= '0;
      sda_low_o <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      ram_we   <= 1'b0;
      if (start_evt) begin
        st        <= ST_SEL;
        cnt       <= '0;
        sda_low_o <= 1'b0;
        pending   <= 1'b0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        sda_low_o <= 1'b0;
        commit_o  <= pending;
        pending   <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && cnt != 4'd8) begin
          shreg <= {shreg[6:0], sda_lvl};
          cnt   <= cnt + 1'b1;
        end
        if (scl_fall && cnt != 4'd8 && st == ST_WDATA) pending <= 1'b0;
        if (scl_fall && cnt == 4'd8) begin
          unique case (st)
            ST_SEL: begin
              if (sel_hit) begin
                sda_low_o <= 1'b1;
                rw        <= shreg[0];
                addr      <= AW'({shreg[3:1], addr_lo8});
                st        <= ST_SEL_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              addr      <= AW'({addr_hi3, shreg});
              sda_low_o <= 1'b1;
              st        <= ST_ADDR_ACK;
            end
            default: begin
              if (!wp_i) begin
                ram_we    <= 1'b1;
                wa        <= addr;
                wd        <= shreg;
                addr      <= page_next;
                sda_low_o <= 1'b1;
                pending   <= 1'b1;
              end
              st <= ST_WDATA_ACK;
            end
          endcase
        end
      end else if (scl_fall) begin
        unique case (st)
          ST_SEL_ACK: begin
            if (rw) begin
              out_sh    <= {rd_q[6:0], 1'b0};
              sda_low_o <= ~rd_q[7];
              cnt       <= 4'd1;
              st        <= ST_RDATA;
            end else begin
              sda_low_o <= 1'b0;
              cnt       <= '0;
              st        <= ST_ADDR;
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: begin
            sda_low_o <= 1'b0;
            cnt       <= '0;
            st        <= ST_WDATA;
          end
          ST_RDATA: begin
            if (cnt == 4'd8) begin
              sda_low_o <= 1'b0;
              addr      <= addr + 1'b1;
              st        <= ST_RDATA_ACK;
            end else begin
              sda_low_o <= ~out_sh[7];
              out_sh    <= {out_sh[6:0], 1'b0};
              cnt       <= cnt + 1'b1;
            end
          end
          ST_RDATA_ACK: begin
            if (more) begin
              out_sh    <= {rd_q[6:0], 1'b0};
              sda_low_o <= ~rd_q[7];
              cnt       <= 4'd1;
              st        <= ST_RDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end else if (scl_rise && st == ST_RDATA_ACK) begin
        more <= ~sda_lvl;
      end
    end
  end

  // R4: the line is only ever pulled low while the sampled clock is low
  assert_drive_on_low_scl_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> !scl_lvl);

  // R2: standby never pulls the line
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_low_o);

  // R8: no select acknowledge slot while busy is held
  assert_busy_nak_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_i && $past(busy_i)) |-> (st != ST_SEL_ACK));

  // R7: a commit pulse only follows a detected Stop
  assert_commit_on_stop_R7: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(stop_evt));

  // R6: protected data bytes get no acknowledge
  assert_wp_nak_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDATA_ACK && wp_i) |-> !sda_low_o);

  // R11: the host's acknowledge slot after a read byte is left free
  assert_release_rdack_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDATA_ACK) |-> !sda_low_o);
endmodule

// File: tb/i2c_ee_target_tb_top.sv
module i2c_ee_target_tb_top;
  localparam int Q     = 10;
  localparam int BUSYC = 600;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_low, commit;
  logic busy;
  int   busy_ctr = 0;
  wire  sda_line = m_sda & ~sda_low;

  i2c_ee_target dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_low_o(sda_low), .ce_i(CE), .wp_i(wp), .busy_i(busy),
    .commit_o(commit)
  );

  assign busy = (busy_ctr != 0);
  int commits = 0;
  always @(posedge clk) begin
    if (rst) busy_ctr <= 0;
    else if (commit) busy_ctr <= BUSYC;
    else if (busy_ctr > 0) busy_ctr <= busy_ctr - 1;
    if (!rst && commit) commits <= commits + 1;
  end

  int checks = 0, fails = 0, exp_commits = 0;
  logic [7:0] model [512];
  logic [8:0] m_addr = '0;
  logic [7:0] wbuf [16];
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel_byte(input logic rw, input logic a8);
    return {4'b1010, CE[2], CE[1], a8, rw};
  endfunction

  function automatic logic [8:0] pg_inc(input logic [8:0] a);
    return {a[8:4], a[3:0] + 4'd1};
  endfunction

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1; hq(); m_scl = 1; hq(); m_sda = 0; hq(); m_scl = 0; hq(); endtask
  task automatic bus_stop(); m_sda = 0; hq(); m_scl = 1; hq(); m_sda = 1; hq(); hq(); endtask
  task automatic put_bit(input logic b); m_sda = b; hq(); m_scl = 1; hq(); hq(); m_scl = 0; hq(); endtask
  task automatic get_bit(output logic b); m_sda = 1; hq(); m_scl = 1; hq(); b = sda_line; hq(); m_scl = 0; hq(); endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack);
  endtask

  task automatic wait_free();
    repeat (8) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    logic ack;
    logic [8:0] pa;
    bus_start();
    wr_byte(sel_byte(0, a[8]), ack); chk("R4 select ack", ack, 1);
    wr_byte(a[7:0], ack);            chk("R4/R6 address ack", ack, 1);
    pa = a;
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      chk(wp ? "R6 data nak" : "R4 data ack", ack, !wp);
      if (!wp) model[pa] = wbuf[i];
      pa = pg_inc(pa);
    end
    bus_stop();
    if (!wp && n > 0) exp_commits++;
    m_addr = wp ? a : pa;
    repeat (8) @(negedge clk);
    chk("R7 commit count", commits, exp_commits);
    wait_free();
  endtask

  task automatic do_read(input logic [8:0] a, input int n);
    logic ack;
    logic [7:0] v;
    logic [8:0] ra;
    bus_start();
    wr_byte(sel_byte(0, a[8]), ack); chk("R9 dummy select ack", ack, 1);
    wr_byte(a[7:0], ack);            chk("R9 address ack", ack, 1);
    bus_start();
    wr_byte(sel_byte(1, a[8]), ack); chk("R9 read select ack", ack, 1);
    ra = a;
    for (int i = 0; i < n; i++) begin
      rd_byte(v, i < n - 1);
      chk("R9/R10 read data", v, model[ra]);
      ra = ra + 9'd1;
    end
    bus_stop();
    m_addr = ra;
    repeat (4) @(negedge clk);
  endtask

  task automatic cur_read(input logic a8);
    logic ack;
    logic [7:0] v;
    bus_start();
    wr_byte(sel_byte(1, a8), ack); chk("R10 current select ack", ack, 1);
    m_addr = {a8, m_addr[7:0]};
    rd_byte(v, 0);
    chk("R10 current read data", v, model[m_addr]);
    m_addr = m_addr + 9'd1;
    repeat (6) @(negedge clk);
    chk("R11 released after nak", sda_low, 0);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset line released", sda_low, 0);
    chk("R12 reset commit low", commit, 0);

    // R12: erased array; R10 current read from counter 0; R11 nak release
    cur_read(0);

    // R2: enable pin mismatch and wrong type are not acknowledged
    bus_start();
    wr_byte({4'b1010, ~CE[2], CE[1], 1'b0, 1'b1}, ack); chk("R2 pin mismatch nak", ack, 0);
    wr_byte(8'h00, ack); chk("R2 ignored until start", ack, 0);
    bus_stop();
    bus_start();
    wr_byte({4'b1011, CE[2], CE[1], 1'b0, 1'b0}, ack); chk("R2 type mismatch nak", ack, 0);
    bus_stop();

    // R4/R7 byte write, then R8 polling while busy
    wbuf[0] = 8'hA5;
    bus_start();
    wr_byte(sel_byte(0, 0), ack); chk("R4 select ack", ack, 1);
    wr_byte(8'h05, ack);          chk("R4 address ack", ack, 1);
    wr_byte(8'hA5, ack);          chk("R4 data ack", ack, 1);
    bus_stop();
    model[5] = 8'hA5; exp_commits++;
    repeat (8) @(negedge clk);
    chk("R7 commit after data", commits, exp_commits);
    bus_start();
    wr_byte(sel_byte(0, 0), ack); chk("R8 busy nak", ack, 0);
    bus_stop();
    wait_free();

    // R3: A8 in select reaches the upper half
    wbuf[0] = 8'h3C;
    do_write(9'h105, 1);
    do_read(9'h005, 1);
    do_read(9'h105, 1);

    // R5: page wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(9'h01E, 4);
    do_read(9'h010, 4);
    do_read(9'h01E, 2);
    chk("R5 wrapped byte", model[9'h010], 8'h33);

    // R6: write protect
    wp = 1; wbuf[0] = 8'h77;
    do_write(9'h020, 1);
    wp = 0;
    do_read(9'h020, 1);

    // R7: stop after address only gives no commit
    bus_start();
    wr_byte(sel_byte(0, 0), ack);
    wr_byte(8'h40, ack);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R7 no commit after address", commits, exp_commits);
    m_addr = 9'h040;

    // R10: sequential wrap from last address
    wbuf[0] = 8'h9A;
    do_write(9'h1FF, 1);
    do_read(9'h1FE, 4);
    chk("R10 counter wrapped", m_addr, 9'h002);
    cur_read(0);

    // R1: start in the middle of a data byte aborts it
    wbuf[0] = 8'h5E;
    do_write(9'h040, 1);
    bus_start();
    wr_byte(sel_byte(0, 0), ack);
    wr_byte(8'h40, ack);
    put_bit(0); put_bit(0); put_bit(1);
    bus_start();
    wr_byte(sel_byte(1, 0), ack); chk("R1 restart select ack", ack, 1);
    rd_byte(v, 0);
    chk("R1 aborted byte not stored", v, 8'h5E);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R1 no commit on abort", commits, exp_commits);

    // random page writes and reads
    for (int k = 0; k < 6; k++) begin
      int n;
      logic [8:0] a;
      a = 9'($urandom % 512);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n);
    end
    for (int k = 0; k < 6; k++) begin
      do_read(9'($urandom % 512), 1 + int'($urandom % 4));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule